// File: doc/BRIEF.md
# Paired-Register Multiply-Accumulate Unit

This unit is a multi-cycle arithmetic engine that sits beside a 32-bit integer pipeline and updates a 64-bit accumulator kept in two neighbouring general registers. On a start strobe it captures an opcode and three register indices. It then reads both 32-bit sources and both accumulator words through a register file that has two read ports and one write port. It forms either two 16x16 products, one 32x32 product, or a plain 64-bit addend, and adds or subtracts that into the accumulator. It writes the 64-bit result back one word per cycle.

The sequencer has six named states. `ST_IDLE` waits for a start strobe. `ST_RD_SRC` reads the two sources. `ST_RD_ACC` reads the accumulator pair and computes the result. `ST_WR_LO` writes the low word. `ST_WR_HI` writes the high word. `ST_FINISH` raises done. The transitions are `ST_IDLE` to `ST_RD_SRC` when start is sampled high, and then an unconditional one-step chain `ST_RD_SRC` to `ST_RD_ACC` to `ST_WR_LO` to `ST_WR_HI` to `ST_FINISH` to `ST_IDLE`. Hazard checking and instruction decode belong to the surrounding core.

Top module: `pair_mac_unit`

## Requirements
- R1: When opcode bits [2:1] = 00 (dual mode), the new accumulator is the old one plus the product of the low 16-bit halves of source 1 and source 2, plus the product of their high 16-bit halves.
- R2: When opcode bits [2:1] = 01 (wide mode), the new accumulator is the old one plus the full 32x32 product of source 1 and source 2.
- R3: When opcode bits [2:1] = 10, the 64-bit value {source 2, source 1} is added to the accumulator. Source 1 supplies bits 31:0 of that value. When bits [2:1] = 11, the same value is subtracted from the accumulator.
- R4: Opcode bit 0 = 0 selects signed operation, and bit 0 = 1 selects unsigned operation. In signed operation, the halves, words, products, addend and accumulator are sign-extended. In unsigned operation they are zero-extended.
- R5: The accumulator occupies registers `pair_idx` with bit 0 cleared (bits 31:0) and that index plus one (bits 63:32). Bit 0 of `pair_idx` is ignored.
- R6: Counting the edge that accepts start as the start of cycle 1, the cycles run as follows. Cycle 1 reads the sources. Cycle 2 reads the accumulator pair. Cycle 3 writes the low word to the even register. Cycle 4 writes the high word to the odd register. `wr_en` is high in no other cycle.
- R7: `done` is high for exactly cycle 5. `busy` is high in cycles 1 to 5 and low in the cycle that follows.
- R8: A start strobe sampled while `busy` is high is ignored. The running operation finishes unchanged, and no further operation begins.
- R9: The result wraps modulo 2^64. The `ovf` flag, valid from `done` onward, reports one of two conditions. For unsigned operations it is the carry or borrow out of bit 63. For signed operations it is two's-complement overflow of the 64-bit result.
- R10: After reset the unit is in `ST_IDLE`, with `busy`, `done`, `wr_en` and `ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| op | input | 3 | Operation: [2:1] kind, [0] unsigned |
| src1_idx | input | AW | Index of source 1 |
| src2_idx | input | AW | Index of source 2 |
| pair_idx | input | AW | Accumulator pair index (bit 0 ignored) |
| rd0_addr | output | AW | Read port 0 address |
| rd0_data | input | W | Read port 0 data (same cycle) |
| rd1_addr | output | AW | Read port 1 address |
| rd1_data | input | W | Read port 1 data (same cycle) |
| wr_en | output | 1 | Write enable |
| wr_addr | output | AW | Write address |
| wr_data | output | W | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Carry, borrow or signed overflow of the last result |

## Verification
The bench uses the default parameters: W = 32, which gives 16-bit lanes, and AW = 5, which gives a 32-entry register file. With these values the most negative and all-ones halves and words can be driven directly. The accumulator can be pushed to the positive limit, the negative limit and the unsigned limit, so every flag condition can be produced. The 32-entry file also leaves room to place the pair at an odd index, and to aim an ignored start at registers whose contents are then checked for being untouched.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_ACC,
        ST_WR_LO,
        ST_WR_HI,
        ST_FINISH
    } pmac_state_t;

    typedef enum logic [1:0] {
        K_DUAL = 2'b00,
        K_WIDE = 2'b01,
        K_ADD  = 2'b10,
        K_SUB  = 2'b11
    } pmac_kind_t;
endpackage

// File: rtl/pmac_fsm.sv
module pmac_fsm
    import pmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output pmac_state_t state_o
);
    pmac_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RD_SRC;
            ST_RD_SRC: state_d = ST_RD_ACC;
            ST_RD_ACC: state_d = ST_WR_LO;
            ST_WR_LO:  state_d = ST_WR_HI;
            ST_WR_HI:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pmac_arith.sv
module pmac_arith
    import pmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]     kind,
    input  logic           uns,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] res,
    output logic           flag
);
    localparam int HW    = W / 2;
    localparam int DW    = 2 * W;
    localparam int EW    = DW + 2;
    localparam int LANES = 2;

    logic          sgn;
    logic [W-1:0]  lane_p [LANES];
    logic [DW-1:0] wa, wb, wprod;
    logic [EW-1:0] acc_x, t0, t1, sum_x;

    assign sgn = ~uns;

    // one half-width multiplier per lane; operands extended to W bits so the
    // truncated product equals the exact signed or unsigned product
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HW-1:0] ha, hb;
        logic [W-1:0]  xa, xb;
        assign ha = a[g*HW +: HW];
        assign hb = b[g*HW +: HW];
        assign xa = {{HW{sgn & ha[HW-1]}}, ha};
        assign xb = {{HW{sgn & hb[HW-1]}}, hb};
        assign lane_p[g] = xa * xb;
    end

    assign wa    = {{W{sgn & a[W-1]}}, a};
    assign wb    = {{W{sgn & b[W-1]}}, b};
    assign wprod = wa * wb;

    always_comb begin
        acc_x = {{2{sgn & acc[DW-1]}}, acc};
        t0    = '0;
        t1    = '0;
        unique case (pmac_kind_t'(kind))
            K_DUAL: begin
                t0 = {{(EW-W){sgn & lane_p[0][W-1]}}, lane_p[0]};
                t1 = {{(EW-W){sgn & lane_p[1][W-1]}}, lane_p[1]};
            end
            K_WIDE:       t0 = {{2{sgn & wprod[DW-1]}}, wprod};
            K_ADD, K_SUB: t0 = {{2{sgn & b[W-1]}}, b, a};
            default:      t0 = '0;
        endcase
        if (pmac_kind_t'(kind) == K_SUB) sum_x = acc_x - t0;
        else                             sum_x = acc_x + t0 + t1;
    end

    assign res  = sum_x[DW-1:0];
    assign flag = uns ? (|sum_x[EW-1:DW])
                      : !((sum_x[EW-1:DW-1] == 3'b000) || (sum_x[EW-1:DW-1] == 3'b111));
endmodule

// File: rtl/pair_mac_unit.sv
module pair_mac_unit
    import pmac_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] src1_idx,
    input  logic [AW-1:0] src2_idx,
    input  logic [AW-1:0] pair_idx,
    output logic [AW-1:0] rd0_addr,
    input  logic [W-1:0]  rd0_data,
    output logic [AW-1:0] rd1_addr,
    input  logic [W-1:0]  rd1_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          busy,
    output logic          done,
    output logic          ovf
);
    localparam int DW = 2 * W;
    localparam logic [AW-1:0] ODD = {{(AW-1){1'b0}}, 1'b1};

    pmac_state_t   state;
    logic [2:0]    op_q;
    logic [AW-1:0] s1_q, s2_q, base_q;
    logic [W-1:0]  a_q, b_q;
    logic [DW-1:0] res_q, sum;
    logic          ovf_q, flag;

    pmac_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state_o(state)
    );

    pmac_arith #(.W(W)) u_arith (
        .kind(op_q[2:1]),
        .uns (op_q[0]),
        .a   (a_q),
        .b   (b_q),
        .acc ({rd1_data, rd0_data}),
        .res (sum),
        .flag(flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            s1_q   <= '0;
            s2_q   <= '0;
            base_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            res_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    op_q   <= op;
                    s1_q   <= src1_idx;
                    s2_q   <= src2_idx;
                    base_q <= pair_idx & ~ODD;
                end
                ST_RD_SRC: begin
                    a_q <= rd0_data;
                    b_q <= rd1_data;
                end
                ST_RD_ACC: begin
                    res_q <= sum;
                    ovf_q <= flag;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd0_addr = '0;
        rd1_addr = '0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_RD_SRC: begin
                rd0_addr = s1_q;
                rd1_addr = s2_q;
            end
            ST_RD_ACC: begin
                rd0_addr = base_q;
                rd1_addr = base_q | ODD;
            end
            ST_WR_LO: begin
                wr_en   = 1'b1;
                wr_addr = base_q;
                wr_data = res_q[W-1:0];
            end
            ST_WR_HI: begin
                wr_en   = 1'b1;
                wr_addr = base_q | ODD;
                wr_data = res_q[DW-1:W];
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign ovf = ovf_q;
endmodule

// File: rtl/pmac_chk.sv
module pmac_chk #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic          busy,
    input logic          done
);
    p_wr_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    p_lo_then_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[0]) |=> (wr_en && wr_addr == {$past(wr_addr[AW-1:1]), 1'b1}));

    p_hi_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=> done);

    p_wr_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, done}));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && !wr_en));

    p_rise_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (!wr_en && !done && wr_data == '0));
endmodule

bind pair_mac_unit pmac_chk #(.W(W), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_pair_mac_unit.sv
`timescale 1ns/1ps
module sim_pair_mac_unit;
    localparam int W  = 32;
    localparam int AW = 5;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_i = '0;
    logic [AW-1:0] s1_i = '0, s2_i = '0, pr_i = '0;
    logic [AW-1:0] rd0_addr, rd1_addr, wr_addr;
    logic [W-1:0]  rd0_data, rd1_data, wr_data;
    logic          wr_en, busy, done, ovf;
    logic          pl_en = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [W-1:0]  pl_data = '0;
    logic [W-1:0]  rf [32];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pair_mac_unit #(.W(W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i),
        .src1_idx(s1_i), .src2_idx(s2_i), .pair_idx(pr_i),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .ovf(ovf)
    );

    assign rd0_data = rf[rd0_addr];
    assign rd1_data = rf[rd1_addr];

    always @(posedge clk) begin
        if (wr_en) rf[wr_addr] <= wr_data;
        if (pl_en) rf[pl_addr] <= pl_data;
    end

    // stimulus table: op, source 1, source 2, accumulator
    localparam logic [2:0]  V_OP  [NV] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101,
                                           3'b111, 3'b100, 3'b110, 3'b010, 3'b000};
    localparam logic [31:0] V_A   [NV] = '{32'hFFFE_0003, 32'hFFFF_FFFF, 32'h8000_0000,
                                           32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0002,
                                           32'h0000_0000, 32'h0000_0005, 32'hFFFF_FFFD,
                                           32'h0001_0001};
    localparam logic [31:0] V_B   [NV] = '{32'h0005_FFF9, 32'hFFFF_FFFF, 32'h8000_0000,
                                           32'h0000_0002, 32'h0000_0000, 32'h0000_0000,
                                           32'h0000_0001, 32'h0000_0000, 32'h0000_0007,
                                           32'h0001_0001};
    localparam logic [63:0] V_ACC [NV] = '{64'd100, 64'hFFFF_FFFF_0000_0000, 64'd0,
                                           64'd1234, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
                                           64'h7FFF_FFFF_FFFF_FFFF, 64'd3, 64'd10,
                                           64'h7FFF_FFFF_FFFF_FFFF};

    function automatic logic [64:0] model(input logic [2:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] acc);
        logic sg;
        logic signed [65:0] x, t, s;
        longint p0, p1;
        logic [63:0] pw, v;
        logic fl;
        sg = !o[0];
        x = sg ? {{2{acc[63]}}, acc} : {2'b00, acc};
        t = '0;
        case (o[2:1])
            2'b00: begin
                if (sg) begin
                    p0 = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                    p1 = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
                end else begin
                    p0 = longint'(a[15:0]) * longint'(b[15:0]);
                    p1 = longint'(a[31:16]) * longint'(b[31:16]);
                end
                t = p0;
                t = t + p1;
            end
            2'b01: begin
                if (sg) begin
                    pw = 64'(longint'($signed(a)) * longint'($signed(b)));
                    t = {{2{pw[63]}}, pw};
                end else begin
                    pw = {32'b0, a} * {32'b0, b};
                    t = {2'b00, pw};
                end
            end
            default: begin
                v = {b, a};
                t = sg ? {{2{v[63]}}, v} : {2'b00, v};
            end
        endcase
        s = (o[2:1] == 2'b11) ? x - t : x + t;
        fl = sg ? !((s[65:63] == 3'b000) || (s[65:63] == 3'b111)) : (s[65:64] != 2'b00);
        return {fl, s[63:0]};
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o[2:1])
            2'b00:   return "R1 R4";
            2'b01:   return "R2 R4";
            default: return "R3 R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [AW-1:0] ad, input logic [W-1:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = ad; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] o, input logic [AW-1:0] s1, input logic [AW-1:0] s2,
                         input logic [AW-1:0] pr, input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] acc, input int inj, input string tag);
        logic [AW-1:0] base;
        logic [64:0] m;
        bit ok_busy, ok_wr, ok_done;
        base = {pr[AW-1:1], 1'b0};
        preload(s1, a);
        preload(s2, b);
        preload(base, acc[31:0]);
        preload(base | 5'd1, acc[63:32]);
        m = model(o, a, b, acc);
        ok_busy = 1; ok_wr = 1; ok_done = 1;
        @(negedge clk);
        start = 1'b1; op_i = o; s1_i = s1; s2_i = s2; pr_i = pr;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (!busy) ok_busy = 0;
            if (c == 3 && !(wr_en && wr_addr == base)) ok_wr = 0;
            if (c == 4 && !(wr_en && wr_addr == (base | 5'd1))) ok_wr = 0;
            if (c != 3 && c != 4 && wr_en) ok_wr = 0;
            if ((c == 5) != done) ok_done = 0;
            start = (c == inj);
            if (c == inj) begin
                op_i = 3'b111; s1_i = 5'd30; s2_i = 5'd31; pr_i = 5'd28;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk(ok_wr, {tag, " R5 R6 write order"}, 64'(ok_wr), 64'd1);
        chk(ok_busy && ok_done, {tag, " R7 busy/done timing"}, 64'(ok_done), 64'd1);
        chk(!busy, {tag, " R7 busy low after done"}, 64'(busy), 64'd0);
        chk({rf[base | 5'd1], rf[base]} == m[63:0], {tag, " result"},
            {rf[base | 5'd1], rf[base]}, m[63:0]);
        chk(ovf == m[64], {tag, " R9 ovf"}, 64'(ovf), 64'(m[64]));
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !wr_en && !ovf, "R10 reset state",
            64'({busy, done, wr_en, ovf}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_en, "R10 idle after reset", 64'({busy, wr_en}), 64'd0);

        for (int i = 0; i < NV; i++)
            do_op(V_OP[i], 5'd1, 5'd3, 5'(8 + 2 * (i % 8)), V_A[i], V_B[i], V_ACC[i],
                  0, tag_of(V_OP[i]));

        // R5: odd pair index selects registers 10 and 11
        preload(5'd12, 32'hA5A5_A5A5);
        do_op(3'b000, 5'd2, 5'd5, 5'd11, 32'h0002_0003, 32'h0004_0005, 64'd7, 0, "R5 odd index");
        chk(rf[12] == 32'hA5A5_A5A5, "R5 neighbour untouched", 64'(rf[12]), 64'hA5A5_A5A5);

        // R8: start during cycle 2 and during cycle 5 is ignored
        preload(5'd28, 32'h1111_1111);
        preload(5'd29, 32'h2222_2222);
        do_op(3'b011, 5'd1, 5'd3, 5'd6, 32'h0001_0000, 32'h0001_0000, 64'd5, 2, "R8 start in cycle 2");
        chk({rf[29], rf[28]} == 64'h2222_2222_1111_1111, "R8 ignored target untouched",
            {rf[29], rf[28]}, 64'h2222_2222_1111_1111);
        do_op(3'b100, 5'd1, 5'd3, 5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd1, 5, "R8 start in cycle 5");
        @(negedge clk);
        chk(!busy, "R8 no second operation", 64'(busy), 64'd0);
        chk({rf[29], rf[28]} == 64'h2222_2222_1111_1111, "R8 target still untouched",
            {rf[29], rf[28]}, 64'h2222_2222_1111_1111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule